// File: doc/BRIEF.md
# Dual-Version Memory Array

This block is a synchronous line memory in which each storage location holds two versions of its data. The main copy holds the working (new) value. The shadow copy holds a checkpointed (old) value. Software-visible state can be checkpointed line by line or for the whole array in one operation. A single line can be rolled back from its shadow copy. The main copy alone, the shadow copy alone, or both together can also be read or written directly.

Each request carries a 3-bit opcode, a read/write strobe, a line address and a full line of write data. A request is accepted on a valid/ready handshake when the array is idle. Every request takes two cycles, whatever its kind: a `done` pulse marks completion, and any read result is returned on that same cycle. The top address bit picks one of two sub-banks. The remaining bits pick a row inside that sub-bank. Every line is split into equal slices, and all slices take part in every access.

Top module: `dual_version_array`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `rd_data` is all zeros.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. In the following cycle `req_ready` is 0 and `done` is 0. In the cycle after that, `done` is 1 for one cycle and `req_ready` is 1 again. This holds for every opcode.
- R3: Opcode 3'b100 accesses the main copy of the addressed line. With `req_wr`=1 it stores the whole 512-bit `req_wdata`, in all four 128-bit slices. With `req_wr`=0 it returns the main copy on `rd_data`. The shadow copy does not change.
- R4: Opcode 3'b110 accesses the shadow copy in the same way. The main copy does not change.
- R5: Opcode 3'b001 writes `req_wdata` into both the main and the shadow copy of the addressed line, whatever the value of `req_wr`.
- R6: Opcode 3'b111 copies the main copy of the addressed line into its shadow copy. The main copy and all other lines keep their values.
- R7: Opcode 3'b011 copies the shadow copy of the addressed line into its main copy. The shadow copy and all other lines keep their values.
- R8: Opcode 3'b000 copies the main copy of every line in both sub-banks into its shadow copy in one request.
- R9: Address bit 6 selects the sub-bank (1 selects bank one, 0 selects bank zero) and bits 5:0 select the row. Two addresses that differ only in bit 6 refer to independent lines.
- R10: `rd_data` is zero whenever `rd_oe` is 0. When `rd_oe` is 1, it shows the result of the most recent read, which is held until the next read completes.
- R11: Opcodes 3'b010 and 3'b101 change no copy and no held read result, for either value of `req_wr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Array idle, request can be taken |
| req_op | input | 3 | Operation code |
| req_wr | input | 1 | 1 = write, 0 = read, for single-copy opcodes |
| req_addr | input | 7 | Line address; bit 6 selects the sub-bank |
| req_wdata | input | 512 | Write data |
| rd_oe | input | 1 | Read output enable |
| rd_data | output | 512 | Read result, zero while `rd_oe` is low |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every line is first loaded through the both-copies write with a pattern unique to its address and to each 32-bit lane. This makes any cross-line, cross-bank or cross-slice leak visible. Single-copy writes then make main and shadow differ on selected lines. Reading both copies back shows whether a save, a restore or a direct access touched the wrong copy or a neighbouring line. The no-op codes are sent with write data that differs from the stored data, on a line that was just read, so any accidental write or read path changes what is observed. The whole-array save comes last, when many lines hold different main and shadow values, so one operation is checked against both sub-banks and the array edges.

// File: rtl/dv_array_pkg.sv
package dv_array_pkg;

  typedef enum logic [2:0] {
    OP_SAVE_ALL = 3'b000,
    OP_BOTH     = 3'b001,
    OP_IDLE_A   = 3'b010,
    OP_RESTORE  = 3'b011,
    OP_MAIN     = 3'b100,
    OP_IDLE_B   = 3'b101,
    OP_SHADOW   = 3'b110,
    OP_SAVE     = 3'b111
  } dv_op_e;

  typedef struct packed {
    logic en_main;
    logic en_shadow;
    logic save_line;
    logic restore_line;
    logic save_all;
  } dv_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_DONE = 2'd2
  } dv_state_e;

endpackage

// File: rtl/dv_op_decode.sv
module dv_op_decode
  import dv_array_pkg::*;
(
  input  logic [2:0] op,
  output dv_ctl_t    ctl
);
  logic a, b, c;

  always_comb begin
    a = op[2];
    b = op[1];
    c = op[0];
    ctl.en_main      = (a & ~b & ~c) | (~a & ~b & c);
    ctl.en_shadow    = (~a & ~b & c) | (a & b & ~c);
    ctl.save_line    = a & b & c;
    ctl.restore_line = ~a & b & c;
    ctl.save_all     = ~a & ~b & ~c;
  end
endmodule

// File: rtl/dv_slice.sv
module dv_slice #(
  parameter int ROW_W = 6,
  parameter int W     = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [ROW_W-1:0] row,
  input  logic             wr_main,
  input  logic             wr_shadow,
  input  logic             save_line,
  input  logic             restore_line,
  input  logic             save_all,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rd_main,
  output logic [W-1:0]     rd_shadow
);
  localparam int ROWS = 1 << ROW_W;

  logic [W-1:0] main_q   [ROWS];
  logic [W-1:0] shadow_q [ROWS];

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (sel && (row == ROW_W'(r))) begin
        if (wr_main) begin
          main_q[r] <= wdata;
        end else if (restore_line) begin
          main_q[r] <= shadow_q[r];
        end
      end
      if (save_all || (sel && (row == ROW_W'(r)) && save_line)) begin
        shadow_q[r] <= main_q[r];
      end else if (sel && (row == ROW_W'(r)) && wr_shadow) begin
        shadow_q[r] <= wdata;
      end
    end
  end

  always_comb begin
    rd_main   = main_q[row];
    rd_shadow = shadow_q[row];
  end

  AST_LINE_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && save_line) |=> (rd_shadow == $past(rd_main)));  // R6
  AST_LINE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && restore_line) |=> (rd_main == $past(rd_shadow)));  // R7
  AST_BOTH_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_main && wr_shadow) |=> (rd_main == rd_shadow));  // R5
endmodule

// File: rtl/dv_bank.sv
module dv_bank #(
  parameter int ROW_W   = 6,
  parameter int WORD_W  = 512,
  parameter int SLICE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ROW_W-1:0]  row,
  input  logic              wr_main,
  input  logic              wr_shadow,
  input  logic              save_line,
  input  logic              restore_line,
  input  logic              save_all,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_main,
  output logic [WORD_W-1:0] rd_shadow
);
  localparam int NSLICE = WORD_W / SLICE_W;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    dv_slice #(.ROW_W(ROW_W), .W(SLICE_W)) u_slice (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel          (sel),
      .row          (row),
      .wr_main      (wr_main),
      .wr_shadow    (wr_shadow),
      .save_line    (save_line),
      .restore_line (restore_line),
      .save_all     (save_all),
      .wdata        (wdata[s*SLICE_W +: SLICE_W]),
      .rd_main      (rd_main[s*SLICE_W +: SLICE_W]),
      .rd_shadow    (rd_shadow[s*SLICE_W +: SLICE_W])
    );
  end
endmodule

// File: rtl/dual_version_array.sv
module dual_version_array
  import dv_array_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int WORD_W  = 512,
  parameter int SLICE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              rd_oe,
  output logic [WORD_W-1:0] rd_data,
  output logic              done
);
  localparam int ROW_W  = ADDR_W - 1;
  localparam int NBANK  = 2;

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  dv_state_e         state_q, state_d;
  logic              accept;
  logic [2:0]        op_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] rdata_q;
  dv_ctl_t           ctl;
  logic              exec;
  logic              bank_idx;
  logic [ROW_W-1:0]  row;
  logic              do_wr_main, do_wr_shadow, do_read;
  logic [WORD_W-1:0] bank_rd_main   [NBANK];
  logic [WORD_W-1:0] bank_rd_shadow [NBANK];

  assign req_ready = (state_q != ST_EXEC);
  assign done      = (state_q == ST_DONE);
  assign accept    = req_valid & req_ready;
  assign exec      = (state_q == ST_EXEC);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_EXEC;
      ST_EXEC: state_d = ST_DONE;
      ST_DONE: state_d = accept ? ST_EXEC : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      op_q    <= req_op;
      wr_q    <= req_wr;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  dv_op_decode u_dec (
    .op  (op_q),
    .ctl (ctl)
  );

  always_comb begin
    bank_idx     = addr_q[ADDR_W-1];
    row          = addr_q[ROW_W-1:0];
    do_wr_main   = exec & ctl.en_main &
                   (ctl.en_shadow | wr_q);
    do_wr_shadow = exec & ctl.en_shadow &
                   (ctl.en_main | wr_q);
    do_read      = exec & (ctl.en_main ^ ctl.en_shadow) & ~wr_q;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dv_bank #(.ROW_W(ROW_W), .WORD_W(WORD_W), .SLICE_W(SLICE_W)) u_bank (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .sel          (bank_idx == 1'(b)),
      .row          (row),
      .wr_main      (do_wr_main),
      .wr_shadow    (do_wr_shadow),
      .save_line    (exec & ctl.save_line),
      .restore_line (exec & ctl.restore_line),
      .save_all     (exec & ctl.save_all),
      .wdata        (wdata_q),
      .rd_main      (bank_rd_main[b]),
      .rd_shadow    (bank_rd_shadow[b])
    );
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (do_read) begin
      rdata_q <= ctl.en_shadow ? bank_rd_shadow[bank_idx] : bank_rd_main[bank_idx];
    end
  end

  assign rd_data = rd_oe ? rdata_q : '0;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_ready) |=> !req_ready);  // R2
  AST_DONE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_ready) |=> ##1 done);  // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);  // R2
  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_oe && $past(rd_oe) && !$past(do_read)) |-> $stable(rd_data));  // R10
endmodule

// File: tb/dual_version_array_test.sv
module dual_version_array_test;
  localparam int AW = 7;
  localparam int DW = 512;
  localparam int NL = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [2:0]    req_op;
  logic          req_wr;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rd_oe;
  logic [DW-1:0] rd_data;
  logic          done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [DW-1:0] m_main [NL];
  logic [DW-1:0] m_shad [NL];

  always #2 clk = ~clk;

  dual_version_array uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_oe(rd_oe), .rd_data(rd_data), .done(done)
  );

  function automatic logic [DW-1:0] pat(input int seed);
    logic [DW-1:0] d;
    for (int k = 0; k < DW / 32; k++) begin
      d[k*32 +: 32] = (32'(seed) * 32'h9E3779B1) ^ (32'(k) << 24) ^ 32'h5A5A0000;
    end
    return d;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic wr, input int addr,
                       input logic [DW-1:0] wd, output logic [DW-1:0] rd);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_wr = wr;
    req_addr = AW'(addr); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!done && !req_ready, "R2 busy cycle", {510'd0, done, req_ready}, '0);
    @(negedge clk);
    chk(done && req_ready, "R2 done on second cycle", {510'd0, done, req_ready}, {510'd0, 2'b11});
    rd = rd_data;
    case (op)
      3'b100: if (wr) m_main[addr] = wd;
      3'b110: if (wr) m_shad[addr] = wd;
      3'b001: begin m_main[addr] = wd; m_shad[addr] = wd; end
      3'b111: m_shad[addr] = m_main[addr];
      3'b011: m_main[addr] = m_shad[addr];
      3'b000: for (int i = 0; i < NL; i++) m_shad[i] = m_main[i];
      default: ;
    endcase
  endtask

  task automatic chk_main(input int addr, input string tag);
    logic [DW-1:0] r;
    do_op(3'b100, 1'b0, addr, '0, r);
    chk(r === m_main[addr], tag, r, m_main[addr]);
  endtask

  task automatic chk_shad(input int addr, input string tag);
    logic [DW-1:0] r;
    do_op(3'b110, 1'b0, addr, '0, r);
    chk(r === m_shad[addr], tag, r, m_shad[addr]);
  endtask

  task automatic t_reset;
    chk(req_ready === 1'b1, "R1 ready after reset", {511'd0, req_ready}, 1);
    chk(done === 1'b0, "R1 done after reset", {511'd0, done}, 0);
    chk(rd_data === '0, "R1 rd_data after reset", rd_data, '0);
  endtask

  task automatic t_fill;
    logic [DW-1:0] r;
    for (int i = 0; i < NL; i++) do_op(3'b001, i[0], i, pat(i), r);
    chk_main(0, "R5 fill main line 0");
    chk_shad(127, "R5 fill shadow line 127");
  endtask

  task automatic t_main;
    logic [DW-1:0] r;
    do_op(3'b100, 1'b1, 5, pat(1000), r);
    chk_main(5, "R3 main write/read all slices");
    chk_shad(5, "R3 shadow untouched");
  endtask

  task automatic t_shadow;
    logic [DW-1:0] r;
    do_op(3'b110, 1'b1, 9, pat(2000), r);
    chk_shad(9, "R4 shadow write/read");
    chk_main(9, "R4 main untouched");
  endtask

  task automatic t_both;
    logic [DW-1:0] r;
    do_op(3'b001, 1'b0, 20, pat(3000), r);
    chk_main(20, "R5 both write main");
    chk_shad(20, "R5 both write shadow");
  endtask

  task automatic t_save;
    logic [DW-1:0] r;
    do_op(3'b100, 1'b1, 30, pat(4000), r);
    do_op(3'b111, 1'b0, 30, pat(4444), r);
    chk_shad(30, "R6 save copies main to shadow");
    chk_main(30, "R6 main kept");
    chk_shad(31, "R6 neighbour kept");
  endtask

  task automatic t_restore;
    logic [DW-1:0] r;
    do_op(3'b100, 1'b1, 40, pat(5000), r);
    do_op(3'b100, 1'b1, 41, pat(5100), r);
    do_op(3'b011, 1'b1, 40, pat(5555), r);
    chk_main(40, "R7 restore copies shadow to main");
    chk_shad(40, "R7 shadow kept");
    chk_main(41, "R7 neighbour kept");
  endtask

  task automatic t_bank;
    logic [DW-1:0] r;
    do_op(3'b100, 1'b1, 3, pat(6000), r);
    do_op(3'b110, 1'b1, 67, pat(6100), r);
    chk_main(67, "R9 bank one row 3 main independent");
    chk_shad(3, "R9 bank zero row 3 shadow independent");
    chk_main(3, "R9 bank zero row 3 main");
  endtask

  task automatic t_noop;
    logic [DW-1:0] r;
    logic [DW-1:0] held;
    do_op(3'b100, 1'b0, 5, '0, held);
    do_op(3'b010, 1'b1, 5, pat(7000), r);
    chk(r === held, "R11 op 010 keeps read result", r, held);
    do_op(3'b101, 1'b0, 5, pat(7100), r);
    chk(r === held, "R11 op 101 keeps read result", r, held);
    do_op(3'b101, 1'b1, 9, pat(7200), r);
    chk_main(5, "R11 main unchanged by no-ops");
    chk_shad(5, "R11 shadow unchanged by no-ops");
    chk_shad(9, "R11 shadow line 9 unchanged");
  endtask

  task automatic t_oe;
    logic [DW-1:0] r;
    do_op(3'b100, 1'b0, 20, '0, r);
    rd_oe = 1'b0;
    #1;
    chk(rd_data === '0, "R10 zero while oe low", rd_data, '0);
    do_op(3'b100, 1'b1, 21, pat(8000), r);
    chk(r === '0, "R10 zero while oe low after write", r, '0);
    rd_oe = 1'b1;
    #1;
    chk(rd_data === m_main[20], "R10 held read result", rd_data, m_main[20]);
  endtask

  task automatic t_save_all;
    logic [DW-1:0] r;
    do_op(3'b100, 1'b1, 0, pat(9000), r);
    do_op(3'b100, 1'b1, 127, pat(9100), r);
    do_op(3'b000, 1'b1, 64, pat(9200), r);
    chk_shad(0, "R8 save-all line 0");
    chk_shad(127, "R8 save-all line 127");
    chk_shad(5, "R8 save-all line 5");
    chk_shad(9, "R8 save-all line 9");
    chk_shad(67, "R8 save-all bank one");
    chk_main(127, "R8 main kept");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 3'b010; req_wr = 1'b0;
    req_addr = '0; req_wdata = '0; rd_oe = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_fill;
    t_main;
    t_shadow;
    t_both;
    t_save;
    t_restore;
    t_bank;
    t_noop;
    t_oe;
    t_save_all;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule